// File: doc/BRIEF.md
# Externally clocked synchronous serial transmitter with one-word buffer

This block sends words over a synchronous serial link whose shift clock is owned by a remote master. The remote side drives the clock pin and the block only follows it. A host writes a byte, plus an optional ninth bit, through a single-cycle strobe. The word goes straight into the transmit shifter when that shifter is free. Otherwise it waits in a one-word holding register.

Each bit is put on the data line after a falling edge of the external clock, so the master can sample it on the following rising edge. The external clock reaches the system clock domain through a two-flop synchronizer, and its falling edges are detected there. The block is active only when the port is enabled, synchronous mode is chosen, the clock source is set to external, transmit is enabled and both receive enables are off. In any other setting it holds itself cleared.

The host sees three status outputs. One shows that the holding register is empty. One is an interrupt request, which is that flag gated by an enable input. The third shows that the whole transmit path is empty.

Top module: `ext_clk_sync_tx`

## Requirements
- R1: The block is active only when port_en=1, sync_sel=1, clk_src_int=0, tx_en=1, rx_cont_en=0 and rx_single_en=0. In the cycle after any inactive cycle, the following hold: any word in progress or held is discarded, hold_empty=1, shift_empty=1 and sdata_out=1. Strobes seen while inactive are ignored.
- R2: After synchronous reset, hold_empty=1, shift_empty=1, sdata_out=1, and irq equals irq_en.
- R3: A write while the shifter is idle and the holding register is empty loads the shifter directly. In the next cycle shift_empty=0, hold_empty stays 1, and sdata_out shows bit 0 of the written byte.
- R4: A write while a word is shifting goes into the holding register, and hold_empty stays 0 until the current word ends. At the falling edge that ends the current word, the held word moves into the shifter and hold_empty returns to 1.
- R5: Bits go out least significant first. Bit 0 is shown from the load. Each later bit appears two system cycles after the first system clock edge that samples sclk_in low following a high sample (synchronizer plus edge register). The word ends at the falling edge after its last bit.
- R6: The word length is latched when the word is loaded. When nine_bit_sel=1 at load, the ninth bit captured from wr_bit9 together with the byte is sent after byte bit 7, giving 9 bits. When nine_bit_sel=0, 8 bits are sent.
- R7: A write while the holding register is already full is ignored, and the held word is kept.
- R8: irq is 1 exactly when irq_en=1 and hold_empty=1.
- R9: shift_empty is 1 exactly when no word is shifting and the holding register is empty.
- R10: sdata_out is 1 whenever no word is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe for the holding path |
| wr_data | input | 8 | Data byte to send |
| wr_bit9 | input | 1 | Ninth data bit, captured with the byte |
| port_en | input | 1 | Serial port enable |
| sync_sel | input | 1 | 1 selects synchronous mode |
| clk_src_int | input | 1 | 0 selects the external shift clock |
| tx_en | input | 1 | Transmit enable |
| nine_bit_sel | input | 1 | 1 selects 9-bit words |
| rx_cont_en | input | 1 | Continuous receive enable, must be 0 |
| rx_single_en | input | 1 | Single receive enable, must be 0 |
| irq_en | input | 1 | Interrupt enable |
| sclk_in | input | 1 | External shift clock from the master |
| sdata_out | output | 1 | Serial data, changes after falling edges |
| hold_empty | output | 1 | Holding register empty |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Whole transmit path empty |

## Verification
The bench sends a lone word to an idle shifter, which separates the direct load from a pass through the holding register. Back-to-back writes show whether the hand-off happens exactly at the final falling edge, and a burst of three writes shows whether a write into a full buffer overwrites the held word or is dropped. Nine-bit words whose ninth bit differs from bit 7 expose both a wrong length and a wrong bit order. Dropping each enable condition in turn, including in the middle of a word, separates a full clear from a stall.

// File: rtl/ext_clk_sync_tx_pkg.sv
package ext_clk_sync_tx_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOLD  = 2'd1,
    SRC_WRITE = 2'd2
  } load_src_t;
endpackage

// File: rtl/ectx_edge_det.sv
module ectx_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= sclk_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= 1'b0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

  p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/ectx_hold_reg.sv
module ectx_hold_reg #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              capture,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  output logic              full,
  output logic [WORD_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      full   <= 1'b0;
      word_q <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (capture) begin
      full   <= 1'b1;
      word_q <= word_in;
    end
  end

  p_keep_full_r7: assert property (@(posedge clk) disable iff (rst)
    full && active && !take |=> full && $stable(word_q));
endmodule

// File: rtl/ectx_shifter.sv
module ectx_shifter
  import ext_clk_sync_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          fall,
  input  logic          nine_sel,
  input  logic          hold_full,
  input  logic [DATA_W:0] hold_word,
  input  logic          wr_ok,
  input  logic [DATA_W:0] wr_word,
  output logic          busy,
  output logic          take,
  output logic          sout
);
  localparam int SH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(SH_W);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic             last_bit;
  load_src_t        src;
  logic [SH_W-1:0]  ld_word;

  assign last_bit = busy & fall & (cnt == CNT_ONE);

  always_comb begin
    if (busy)           src = (last_bit && hold_full) ? SRC_HOLD : SRC_NONE;
    else if (hold_full) src = SRC_HOLD;
    else if (wr_ok)     src = SRC_WRITE;
    else                src = SRC_NONE;
  end

  assign take    = (src == SRC_HOLD);
  assign ld_word = (src == SRC_HOLD) ? hold_word : wr_word;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '0;
      sout <= 1'b1;
    end else if (src != SRC_NONE) begin
      busy <= 1'b1;
      sh   <= ld_word;
      cnt  <= nine_sel ? CNT_LONG : CNT_SHORT;
      sout <= ld_word[0];
    end else if (last_bit) begin
      busy <= 1'b0;
      sout <= 1'b1;
    end else if (busy && fall) begin
      sh   <= sh >> 1;
      cnt  <= cnt - CNT_ONE;
      sout <= sh[1];
    end
  end

  p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sout);
  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0) && (cnt <= CNT_LONG));
endmodule

// File: rtl/ext_clk_sync_tx.sv
module ext_clk_sync_tx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              port_en,
  input  logic              sync_sel,
  input  logic              clk_src_int,
  input  logic              tx_en,
  input  logic              nine_bit_sel,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              irq_en,
  input  logic              sclk_in,
  output logic              sdata_out,
  output logic              hold_empty,
  output logic              irq,
  output logic              shift_empty
);
  localparam int WORD_W = DATA_W + 1;

  logic              active;
  logic              wr_ok;
  logic              sclk_fall;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] wr_word;
  logic              busy;
  logic              take;
  logic              capture;

  assign active  = port_en & sync_sel & ~clk_src_int & tx_en & ~rx_cont_en & ~rx_single_en;
  assign wr_ok   = active & wr_stb;
  assign wr_word = {wr_bit9, wr_data};
  assign capture = wr_ok & ~hold_full & busy;

  ectx_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (sclk_in),
    .fall    (sclk_fall)
  );

  ectx_hold_reg #(.WORD_W(WORD_W)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .capture (capture),
    .take    (take),
    .word_in (wr_word),
    .full    (hold_full),
    .word_q  (hold_word)
  );

  ectx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .fall      (sclk_fall),
    .nine_sel  (nine_bit_sel),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .wr_ok     (wr_ok),
    .wr_word   (wr_word),
    .busy      (busy),
    .take      (take),
    .sout      (sdata_out)
  );

  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy & ~hold_full;
  assign irq         = irq_en & hold_empty;

  p_inactive_clears_r1: assert property (@(posedge clk) disable iff (rst)
    !active |=> hold_empty && shift_empty && sdata_out);
  p_direct_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_ok && !busy && !hold_full |=> !shift_empty && hold_empty);
  p_hold_wait_r4: assert property (@(posedge clk) disable iff (rst)
    active && hold_full && busy && !sclk_fall |=> !hold_empty);
  p_take_full_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> hold_full);
endmodule

// File: tb/ext_clk_sync_tx_tb_top.sv
module ext_clk_sync_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_bit9 = 1'b0;
  logic       port_en = 1'b1, sync_sel = 1'b1, clk_src_int = 1'b0, tx_en = 1'b1;
  logic       nine_bit_sel = 1'b0, rx_cont_en = 1'b0, rx_single_en = 1'b0;
  logic       irq_en = 1'b1;
  logic       sclk_in = 1'b1;
  logic       sdata_out, hold_empty, irq, shift_empty;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string data_tag = "R5";

  always #2 clk = ~clk;

  ext_clk_sync_tx dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .port_en(port_en), .sync_sel(sync_sel), .clk_src_int(clk_src_int), .tx_en(tx_en),
    .nine_bit_sel(nine_bit_sel), .rx_cont_en(rx_cont_en), .rx_single_en(rx_single_en),
    .irq_en(irq_en), .sclk_in(sclk_in), .sdata_out(sdata_out), .hold_empty(hold_empty),
    .irq(irq), .shift_empty(shift_empty)
  );

  // Behavioural reference model
  logic m_s0 = 1'b0, m_s1 = 1'b0, m_prev = 1'b0;
  logic m_busy = 1'b0, m_out = 1'b1;
  logic cur[$];
  logic [8:0] hq[$];

  task automatic m_load(input logic [8:0] w);
    cur.delete();
    for (int i = 0; i < 8; i++) cur.push_back(w[i]);
    if (nine_bit_sel) cur.push_back(w[8]);
    m_busy = 1'b1;
    m_out  = cur[0];
  endtask

  always @(posedge clk) begin
    logic fall, act, hf, bp;
    if (rst) begin
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_busy = 0; m_out = 1;
      cur.delete(); hq.delete();
    end else begin
      fall = m_prev & ~m_s1;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = sclk_in;
      act = port_en && sync_sel && !clk_src_int && tx_en && !rx_cont_en && !rx_single_en;
      if (!act) begin
        cur.delete(); hq.delete(); m_busy = 0; m_out = 1;
      end else begin
        hf = (hq.size() != 0);
        bp = m_busy;
        if (m_busy && fall) begin
          void'(cur.pop_front());
          if (cur.size() == 0) begin
            if (hf) m_load(hq.pop_front());
            else begin m_busy = 0; m_out = 1; end
          end else m_out = cur[0];
        end else if (!m_busy && hf) m_load(hq.pop_front());
        else if (!m_busy && wr_stb) m_load({wr_bit9, wr_data});
        if (wr_stb && bp && !hf) hq.push_back({wr_bit9, wr_data});
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(data_tag, sdata_out, m_out);
      chk("R4", hold_empty, hq.size() == 0);
      chk("R9", shift_empty, !m_busy && hq.size() == 0);
      chk("R8", irq, irq_en && hq.size() == 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sclk_bits(input int n);
    repeat (n) begin
      sclk_in = 1'b0; step(4);
      sclk_in = 1'b1; step(4);
    end
  endtask

  task automatic write(input logic [7:0] d, input logic b9);
    wr_data = d; wr_bit9 = b9; wr_stb = 1'b1;
    step(1);
    wr_stb = 1'b0;
  endtask

  task automatic set_gate(input int g, input logic bad);
    case (g)
      0: port_en = !bad;
      1: sync_sel = !bad;
      2: clk_src_int = bad;
      3: tx_en = !bad;
      4: rx_cont_en = bad;
      default: rx_single_en = bad;
    endcase
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R2 reset state
    chk("R2", hold_empty, 1'b1);
    chk("R2", shift_empty, 1'b1);
    chk("R2", sdata_out, 1'b1);
    chk("R2", irq, 1'b1);

    // R3 direct load of a lone word
    write(8'h5A, 1'b0);
    chk("R3", hold_empty, 1'b1);
    chk("R3", shift_empty, 1'b0);
    chk("R3", sdata_out, 1'b0);
    sclk_bits(10);
    chk("R10", sdata_out, 1'b1);
    chk("R9", shift_empty, 1'b1);

    // R4 back-to-back words
    write(8'h3C, 1'b0);
    write(8'h81, 1'b0);
    chk("R4", hold_empty, 1'b0);
    sclk_bits(4);
    chk("R4", hold_empty, 1'b0);
    sclk_bits(14);
    chk("R4", hold_empty, 1'b1);

    // R7 third write into a full buffer is dropped
    write(8'h11, 1'b0);
    write(8'h22, 1'b0);
    write(8'h33, 1'b1);
    chk("R7", hold_empty, 1'b0);
    data_tag = "R7";
    sclk_bits(20);
    chk("R7", shift_empty, 1'b1);

    // R6 nine-bit words
    data_tag = "R6";
    nine_bit_sel = 1'b1;
    write(8'h0F, 1'b1);
    write(8'hF0, 1'b0);
    sclk_bits(22);
    nine_bit_sel = 1'b0;
    write(8'hFF, 1'b0);
    sclk_bits(10);
    chk("R6", shift_empty, 1'b1);
    data_tag = "R5";

    // R8 interrupt gating
    irq_en = 1'b0;
    write(8'hC3, 1'b0);
    write(8'h3C, 1'b0);
    chk("R8", irq, 1'b0);
    sclk_bits(20);
    chk("R8", irq, 1'b0);
    irq_en = 1'b1;
    step(1);
    chk("R8", irq, 1'b1);

    // R1 each enable condition, mid-word and while inactive
    for (int g = 0; g < 6; g++) begin
      write(8'hA6, 1'b0);
      write(8'h6A, 1'b0);
      sclk_bits(3);
      set_gate(g, 1'b1);
      step(2);
      chk("R1", hold_empty, 1'b1);
      chk("R1", shift_empty, 1'b1);
      chk("R1", sdata_out, 1'b1);
      write(8'h00, 1'b0);
      step(1);
      chk("R1", shift_empty, 1'b1);
      set_gate(g, 1'b0);
      step(2);
      chk("R1", shift_empty, 1'b1);
      sclk_bits(2);
    end

    step(4);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule